// File: doc/BRIEF.md
# Selectable Biased/Unbiased Rounder

This block rounds a 40-bit accumulator value to the precision of its middle word. The value is split into three fields:

- an 8-bit top part in bits 39:32;
- a 16-bit middle word in bits 31:16;
- a 16-bit low word in bits 15:0.

Rounding adds one to the combined upper 24 bits (top part and middle word) when the low word calls for it. The low word itself comes out unchanged.

A mode input chooses how an exact half is handled. An exact half is a low word of 0x8000.

- In unbiased mode (mode = 0) a tie rounds to even: the upper field goes up only when the middle word is odd.
- In biased mode (mode = 1) every tie rounds up.

The mode is sampled together with each input, so it can change from one item to the next.

A producer presents a value with a valid strobe. The rounded value appears on a registered output one clock later, together with a valid pulse. The output holds its last result between items. A carry out of the middle word runs into the top part. At the 40-bit limit the value wraps to zero and is not saturated.

Top module: `acc_rounder`

## Requirements
- R1: A synchronous reset (rst = 1 at a rising edge) clears outAcc to 0 and outValid to 0 at that edge.
- R2: A low word (bits 15:0) below 0x8000 leaves bits 39:16 unchanged, in both modes.
- R3: A low word above 0x8000 adds one to bits 39:16, in both modes.
- R4: With biasMode = 0 and a low word of exactly 0x8000, bits 39:16 gain one only when bit 16 (the middle-word LSB) is 1. For example, 00_0000_8000 stays 00_0000_8000 and 00_0001_8000 becomes 00_0002_8000.
- R5: With biasMode = 1 and a low word of exactly 0x8000, bits 39:16 always gain one. For example, 00_0000_8000 becomes 00_0001_8000 and 00_0001_8000 becomes 00_0002_8000.
- R6: Bits 15:0 of the result equal bits 15:0 of the input in every case.
- R7: The increment of bits 39:16 is a 24-bit add. A carry out of the middle word propagates into the top part, and an all-ones upper field wraps to zero with no saturation.
- R8: outValid is 1 exactly at the edge after an edge where inValid was 1, and 0 otherwise. The result appears with that same one-cycle latency.
- R9: At an edge where inValid is 0, outAcc keeps its value, whatever inAcc and biasMode are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies inAcc and biasMode for this cycle |
| inAcc | input | 40 | Accumulator value: top part 39:32, middle word 31:16, low word 15:0 |
| biasMode | input | 1 | 1 = every tie rounds up, 0 = ties round to even |
| outValid | output | 1 | One-cycle pulse marking a new result |
| outAcc | output | 40 | Rounded value, held between results |

## Verification
A wrong round-up decision shows up in the very next result: the upper field is off by one, so the scoreboard compares the full 40-bit word on the same cycle as the matching outValid pulse. The tie cases are driven with both even and odd middle words under both modes, and the first wrong item exposes a swapped or ignored mode. A broken carry chain only shows when the middle word is all ones, so vectors that carry into the top part and wrap at 40 bits are included. A latency or hold fault shows within one idle cycle, as a valid pulse out of place or an output that moved while no input was valid.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  // Default field widths of the accumulator word
  localparam int unsigned TOP_W_DEF = 8;
  localparam int unsigned MID_W_DEF = 16;
  localparam int unsigned LOW_W_DEF = 16;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic load;   // capture a new result this edge
    logic bump;   // add one to the upper field
  } rndStrobe_t;

endpackage

// File: rtl/rnd_ctrl.sv
module rnd_ctrl
  import rnd_pkg::*;
#(
  parameter int unsigned LOW_W = LOW_W_DEF
) (
  input  logic             inValid,
  input  logic             biasMode,
  input  logic             midLsb,
  input  logic [LOW_W-1:0] lowWord,
  output rndStrobe_t       strobes
);

  // Exact half of one middle-word unit
  localparam logic [LOW_W-1:0] HALF = {1'b1, {(LOW_W-1){1'b0}}};

  logic isTie;
  logic isAbove;
  logic tieUp;

  always_comb begin
    isTie   = (lowWord == HALF);
    // Above the half: MSB set and any lower bit set
    isAbove = lowWord[LOW_W-1] && (lowWord[LOW_W-2:0] != '0);
    // Biased mode takes every tie; otherwise ties go to even
    tieUp   = isTie && (biasMode || midLsb);
    strobes.load = inValid;
    strobes.bump = isAbove || tieUp;
  end

endmodule

// File: rtl/rnd_dpath.sv
module rnd_dpath
  import rnd_pkg::*;
#(
  parameter int unsigned TOP_W = TOP_W_DEF,
  parameter int unsigned MID_W = MID_W_DEF,
  parameter int unsigned LOW_W = LOW_W_DEF
) (
  input  logic                           clk,
  input  logic                           rst,
  input  rndStrobe_t                     strobes,
  input  logic [TOP_W+MID_W+LOW_W-1:0]   inAcc,
  output logic [TOP_W+MID_W+LOW_W-1:0]   outAcc,
  output logic                           outValid
);

  localparam int unsigned ACC_W = TOP_W + MID_W + LOW_W;
  localparam int unsigned UP_W  = TOP_W + MID_W;

  logic [UP_W-1:0] upperIn;
  logic [UP_W-1:0] upperNext;

  always_comb begin
    upperIn   = inAcc[ACC_W-1:LOW_W];
    // Wrapping add: a carry out of the top part is dropped
    upperNext = upperIn + {{(UP_W-1){1'b0}}, strobes.bump};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outAcc   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.load;
      if (strobes.load) begin
        outAcc <= {upperNext, inAcc[LOW_W-1:0]};
      end
    end
  end

endmodule

// File: rtl/acc_rounder.sv
module acc_rounder
  import rnd_pkg::*;
#(
  parameter int unsigned TOP_W = TOP_W_DEF,
  parameter int unsigned MID_W = MID_W_DEF,
  parameter int unsigned LOW_W = LOW_W_DEF
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic [TOP_W+MID_W+LOW_W-1:0] inAcc,
  input  logic                         biasMode,
  output logic                         outValid,
  output logic [TOP_W+MID_W+LOW_W-1:0] outAcc
);

  rndStrobe_t strobes;

  rnd_ctrl #(
    .LOW_W(LOW_W)
  ) u_ctrl (
    .inValid (inValid),
    .biasMode(biasMode),
    .midLsb  (inAcc[LOW_W]),
    .lowWord (inAcc[LOW_W-1:0]),
    .strobes (strobes)
  );

  rnd_dpath #(
    .TOP_W(TOP_W),
    .MID_W(MID_W),
    .LOW_W(LOW_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inAcc   (inAcc),
    .outAcc  (outAcc),
    .outValid(outValid)
  );

endmodule

// File: rtl/acc_rounder_chk.sv
module acc_rounder_chk #(
  parameter int unsigned TOP_W = 8,
  parameter int unsigned MID_W = 16,
  parameter int unsigned LOW_W = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         inValid,
  input logic [TOP_W+MID_W+LOW_W-1:0] inAcc,
  input logic                         biasMode,
  input logic                         outValid,
  input logic [TOP_W+MID_W+LOW_W-1:0] outAcc
);

  localparam int unsigned ACC_W = TOP_W + MID_W + LOW_W;
  localparam int unsigned UP_W  = TOP_W + MID_W;
  localparam logic [LOW_W-1:0] HALF = {1'b1, {(LOW_W-1){1'b0}}};

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!outValid && outAcc == '0));

  p_below_keep_r2: assert property (@(posedge clk) disable iff (rst)
    (inValid && inAcc[LOW_W-1:0] < HALF) |=> (outAcc == $past(inAcc)));

  p_above_bump_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && inAcc[LOW_W-1:0] > HALF) |=>
      (outAcc[ACC_W-1:LOW_W] == UP_W'($past(inAcc[ACC_W-1:LOW_W]) + 1'b1)));

  p_tie_even_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && !biasMode && inAcc[LOW_W-1:0] == HALF && !inAcc[LOW_W]) |=>
      (outAcc == $past(inAcc)));

  p_tie_odd_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && !biasMode && inAcc[LOW_W-1:0] == HALF && inAcc[LOW_W]) |=>
      (outAcc[ACC_W-1:LOW_W] == UP_W'($past(inAcc[ACC_W-1:LOW_W]) + 1'b1)));

  p_tie_biased_r5: assert property (@(posedge clk) disable iff (rst)
    (inValid && biasMode && inAcc[LOW_W-1:0] == HALF) |=>
      (outAcc[ACC_W-1:LOW_W] == UP_W'($past(inAcc[ACC_W-1:LOW_W]) + 1'b1)));

  p_low_pass_r6: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outAcc[LOW_W-1:0] == $past(inAcc[LOW_W-1:0])));

  p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  p_valid_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(outAcc));

endmodule

bind acc_rounder acc_rounder_chk #(
  .TOP_W(TOP_W),
  .MID_W(MID_W),
  .LOW_W(LOW_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inAcc   (inAcc),
  .biasMode(biasMode),
  .outValid(outValid),
  .outAcc  (outAcc)
);

// File: tb/tb_acc_rounder.sv
`timescale 1ns/1ps
module tb_acc_rounder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [39:0] inAcc = '0;
  logic        biasMode = 1'b0;
  logic        outValid;
  logic [39:0] outAcc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [39:0] expQ[$];
  string       tagQ[$];
  logic [39:0] lastExp = '0;
  logic        validExp = 1'b0;

  always #2.5 clk = ~clk;

  acc_rounder dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inAcc(inAcc),
    .biasMode(biasMode), .outValid(outValid), .outAcc(outAcc)
  );

  task automatic check(input bit ok, input string req,
                       input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%010h expected=%010h", req, act, exp);
    end
  endtask

  // Reference model written from the requirements
  function automatic logic [39:0] model(input logic [39:0] a, input logic b);
    logic [15:0] lo;
    logic        up;
    lo = a[15:0];
    if (lo > 16'h8000)       up = 1'b1;   // R3
    else if (lo == 16'h8000) up = b | a[16]; // R4 / R5
    else                     up = 1'b0;   // R2
    return {a[39:16] + {23'd0, up}, lo};  // R7 wrap in 24 bits
  endfunction

  task automatic sendOne(input logic [39:0] a, input logic b, input string tag);
    @(posedge clk); #1;
    inValid  = 1'b1;
    inAcc    = a;
    biasMode = b;
    expQ.push_back(model(a, b));
    tagQ.push_back(tag);
    lastExp = model(a, b);
  endtask

  task automatic goIdle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      inValid  = 1'b0;
      inAcc    = {8'hA5, 32'h5A5A_8000} ^ {32'd0, 8'(i)};
      biasMode = ~biasMode;
    end
  endtask

  // Expected valid follows inValid by one edge (R8)
  always @(posedge clk) validExp <= rst ? 1'b0 : inValid;

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      check(outValid == validExp, "R8 valid latency", {39'd0, outValid}, {39'd0, validExp});
      if (outValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected result", outAcc, '0);
        end else begin
          logic [39:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(outAcc == e, t, outAcc, e);
          check(outAcc[15:0] == e[15:0], "R6 low word passthrough", outAcc, e);
        end
      end
    end
  end

  initial begin
    logic [39:0] lfsr;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(outValid == 1'b0 && outAcc == '0, "R1 reset state", outAcc, '0);
    rst = 1'b0;

    // Tie cases in both modes
    sendOne(40'h00_0000_8000, 1'b0, "R4 tie even unbiased");
    sendOne(40'h00_0000_8000, 1'b1, "R5 tie even biased");
    sendOne(40'h00_0001_8000, 1'b0, "R4 tie odd unbiased");
    sendOne(40'h00_0001_8000, 1'b1, "R5 tie odd biased");
    // Above and below half
    sendOne(40'h00_0000_8001, 1'b0, "R3 above half unbiased");
    sendOne(40'h00_0001_8001, 1'b1, "R3 above half biased");
    sendOne(40'h00_0000_7FFF, 1'b1, "R2 below half biased");
    sendOne(40'h00_0001_7FFF, 1'b0, "R2 below half unbiased");
    sendOne(40'h3C_1234_0000, 1'b1, "R2 zero low word");
    // Carry and wrap
    sendOne(40'h12_FFFF_C000, 1'b0, "R7 carry into top");
    sendOne(40'hFF_FFFF_FFFF, 1'b0, "R7 wrap at 40 bits");
    sendOne(40'hFF_FFFF_8000, 1'b1, "R7 wrap on biased tie");
    sendOne(40'h7F_FFFE_8000, 1'b0, "R7 even tie no carry");
    goIdle(3);
    check(outAcc == lastExp, "R9 hold while idle", outAcc, lastExp);

    // Pseudo-random stream with gaps
    lfsr = 40'hC3_5A96_1E2D;
    for (int k = 0; k < 300; k++) begin
      lfsr = {lfsr[38:0], lfsr[39] ^ lfsr[37] ^ lfsr[20] ^ lfsr[18]};
      if (k % 7 == 3) begin
        goIdle(1);
      end else if (k % 5 == 0) begin
        sendOne({lfsr[39:16], 16'h8000}, lfsr[3], "R4/R5 random tie");
      end else begin
        sendOne(lfsr, lfsr[5], "R2/R3 random value");
      end
    end
    goIdle(4);
    check(outAcc == lastExp, "R9 hold after stream", outAcc, lastExp);
    check(expQ.size() == 0, "R8 all results delivered",
          40'(expQ.size()), '0);

    // Reset mid-operation
    sendOne(40'h01_0203_9000, 1'b0, "R3 before reset");
    goIdle(2);
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    check(outValid == 1'b0 && outAcc == '0, "R1 reset clears result", outAcc, '0);
    rst = 1'b0;
    goIdle(1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule